// File: doc/BRIEF.md
# Shadowed PWM Channel with Prescaler

This block produces one pulse-width modulated output. Its time base comes from one of two tick-enable inputs: a fixed oscillator tick or a bus-clock tick. The chosen tick first goes through a power-of-two divider and then through an 8-bit linear prescaler. Each resulting count tick advances a 16-bit period counter. The output sits at its active level while the counter is below the active count, and at the inactive level for the rest of the period.

Software programs the channel through a small write port with two registers. The wave register holds the period and active counts. The control register holds the prescaler, the divider select, the active level, the source select and the enable. Period, active count and active level are staged and are copied into a working shadow only when the running period wraps. A reprogrammed duty cycle, a reprogrammed period or an inverted polarity therefore never cuts a period short or adds a stray pulse. A ready output tells software when the staging set is free again.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset, pwm_o is 0, ready_o is 1 and err_o is 0. The reset active level is 1, and the reset enable is 0.
- R2: The wave register (wr_addr_i=0) holds the period count P in bits [31:16] and the active count A in bits [15:0]. While running, the counter steps 0,1,..,P and then wraps to 0. The output is active while the count is below A. A=0 gives a constant inactive level, and any A>P (up to 65535) gives a constant active level.
- R3: Divider select S sits in control bits [11:8]. For S from 0 to 8, one divided tick is produced every 2^S source ticks. For S of 9 or more, no ticks are produced and the counter stays where it is.
- R4: Prescaler K sits in control bits [7:0]. It produces one count tick every K+1 divided ticks, so the counter advances every 2^S*(K+1) source ticks.
- R5: Control bit 12 is the active level: 1 means active high and 0 means active low. The inactive level is its complement.
- R6: Control bit 13 selects the tick source: 0 selects osc_tick_i and 1 selects bus_tick_i. The unselected input has no effect.
- R7: A new P, A or active level takes effect only at the count tick that wraps the counter from P to 0. The running period finishes with the old values.
- R8: ready_o falls in the cycle after an accepted wave-register write while running. It rises again at the wrap that loads the shadow.
- R9: A wave-register write while ready_o is 0 is ignored, and it sets err_o. err_o then stays 1 until reset.
- R10: Control bit 14 enables the channel. While the channel is disabled, the counter is held at 0, pwm_o is at the inactive level, ready_o is 1, and the staged values are copied into the shadow. Counting starts one cycle after the enable is written: with one source tick per cycle and D=2^S*(K+1), the count seen j cycles after that is floor(j/D) mod (P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | Oscillator tick enable |
| bus_tick_i | input | 1 | Bus-clock tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 wave, 1 control |
| wr_data_i | input | 32 | Register write data |
| pwm_o | output | 1 | PWM output |
| ready_o | output | 1 | 1 when a wave-register write will be accepted |
| err_o | output | 1 | Sticky flag for a write while busy |

## Verification
The in-RTL properties check the following on every cycle:
- the counter never passes the shadow period;
- the shadow changes only on the cycle the counter returns to zero;
- divided ticks and prescaled ticks are never back to back when their divisor is above one;
- ready drops after an accepted write;
- a busy write leaves the staging register untouched, and the error flag is sticky.

The exact waveform shape can only be shown by the bench scenarios. These compare the output against an arithmetic count model over sweeps of divider, prescaler, period, active count and polarity. The scenarios also cover:
- the mid-period reprogramming sequence, including a combined polarity-and-duty change;
- the frozen counter for an invalid divider select;
- the source-select behaviour.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {
    REG_WAVE = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;

  localparam int CNT_W_DEF   = 16;
  localparam int PRE_W_DEF   = 8;
  localparam int SEL_W_DEF   = 4;
  localparam int SEL_MAX_DEF = 8;
endpackage

// File: rtl/pwm_clk_div.sv
module pwm_clk_div #(
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             osc_tick_i,
  input  logic             bus_tick_i,
  input  logic             src_sel_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (SEL_MAX > 0) ? SEL_MAX : 1;

  logic             src_tick;
  logic             sel_ok;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] mask;

  assign src_tick = src_sel_i ? bus_tick_i : osc_tick_i;
  assign sel_ok   = (sel_i <= SEL_W'(SEL_MAX));

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_i));
  end

  assign tick_o = run_i && src_tick && sel_ok && ((div_cnt & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_cnt <= '0;
    else if (!run_i)   div_cnt <= '0;
    else if (src_tick) div_cnt <= div_cnt + DIV_W'(1);
  end

  // R3: with S>=1 and S held, divided ticks are never on consecutive cycles
  p_div_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0) |=> (!tick_o || !$stable(sel_i)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div_tick_i,
  input  logic [PRE_W-1:0] k_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic             at_top;

  assign at_top = (pre_cnt >= k_i);
  assign tick_o = run_i && div_tick_i && at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_cnt <= '0;
    else if (!run_i)     pre_cnt <= '0;
    else if (div_tick_i) pre_cnt <= at_top ? '0 : pre_cnt + PRE_W'(1);
  end

  // R4: with K>=1 and K held, count ticks are never on consecutive cycles
  p_pre_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && k_i != '0) |=> (!tick_o || !$stable(k_i)));
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] stage_period_i,
  input  logic [CNT_W-1:0] stage_active_i,
  input  logic             stage_pol_i,
  input  logic             wr_accept_i,
  output logic             pending_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sh_period;
  logic [CNT_W-1:0] sh_active;
  logic             sh_pol;
  logic             wrap;
  logic             load;

  assign wrap = tick_i && (cnt == sh_period);
  assign load = !run_i || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!run_i) cnt <= '0;
    else if (tick_i) cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_period <= '0;
      sh_active <= '0;
      sh_pol    <= 1'b1;
    end else if (load) begin
      sh_period <= stage_period_i;
      sh_active <= stage_active_i;
      sh_pol    <= stage_pol_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_o <= 1'b0;
    else         pending_o <= run_i && (wr_accept_i || (pending_o && !load));
  end

  assign pwm_o = (run_i && (cnt < sh_active)) ? sh_pol : ~sh_pol;

  // R2: the running count never passes the shadow period
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt <= sh_period));

  // R7: the shadow set only changes on the cycle the counter is back at 0
  p_shadow_at_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && cnt != '0) |->
      ($stable(sh_period) && $stable(sh_active) && $stable(sh_pol)));
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int PRE_W   = PRE_W_DEF,
  parameter int SEL_W   = SEL_W_DEF,
  parameter int SEL_MAX = SEL_MAX_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_tick_i,
  input  logic               bus_tick_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [2*CNT_W-1:0] wr_data_i,
  output logic               pwm_o,
  output logic               ready_o,
  output logic               err_o
);
  localparam int DATA_W  = 2 * CNT_W;
  localparam int SEL_LSB = PRE_W;
  localparam int POL_BIT = PRE_W + SEL_W;
  localparam int SRC_BIT = POL_BIT + 1;
  localparam int EN_BIT  = POL_BIT + 2;

  logic [DATA_W-1:0] wave_q;
  logic [PRE_W-1:0]  k_q;
  logic [SEL_W-1:0]  sel_q;
  logic              pol_q, src_q, en_q, run_q;
  logic              wave_wr, ctrl_wr, accept;
  logic              div_tick, cnt_tick, pending;

  assign wave_wr = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_WAVE);
  assign ctrl_wr = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_CTRL);
  assign accept  = wave_wr && ready_o;
  assign ready_o = !pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= '0;
      k_q    <= '0;
      sel_q  <= '0;
      pol_q  <= 1'b1;
      src_q  <= 1'b0;
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      run_q <= en_q;
      if (accept) wave_q <= wr_data_i;
      if (wave_wr && !ready_o) err_o <= 1'b1;
      if (ctrl_wr) begin
        k_q   <= wr_data_i[PRE_W-1:0];
        sel_q <= wr_data_i[SEL_LSB +: SEL_W];
        pol_q <= wr_data_i[POL_BIT];
        src_q <= wr_data_i[SRC_BIT];
        en_q  <= wr_data_i[EN_BIT];
      end
    end
  end

  pwm_clk_div #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .osc_tick_i (osc_tick_i),
    .bus_tick_i (bus_tick_i),
    .src_sel_i  (src_q),
    .sel_i      (sel_q),
    .tick_o     (div_tick)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .div_tick_i (div_tick),
    .k_i        (k_q),
    .tick_o     (cnt_tick)
  );

  pwm_period_core #(.CNT_W(CNT_W)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_i          (run_q),
    .tick_i         (cnt_tick),
    .stage_period_i (wave_q[DATA_W-1:CNT_W]),
    .stage_active_i (wave_q[CNT_W-1:0]),
    .stage_pol_i    (pol_q),
    .wr_accept_i    (accept),
    .pending_o      (pending),
    .pwm_o          (pwm_o)
  );

  // R8: an accepted write while running makes the channel busy
  p_ready_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && run_q) |=> !ready_o);

  // R9: a busy write leaves the staged wave word untouched
  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_wr && !ready_o) |=> $stable(wave_q));

  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R10: no busy state while disabled
  p_idle_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> ready_o);
endmodule

// File: tb/pwm_shadow_chan_test.sv
`timescale 1ns/1ps
module pwm_shadow_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b1;
  logic        bus_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pwm, ready, err;
  int          tests = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  pwm_shadow_chan uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .osc_tick_i (osc_tick),
    .bus_tick_i (bus_tick),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .pwm_o      (pwm),
    .ready_o    (ready),
    .err_o      (err)
  );

  function automatic logic [31:0] ctrl(int k, int sel, bit pol, bit src, bit en);
    return 32'(k & 255) | (32'(sel & 15) << 8) | (32'(pol) << 12) |
           (32'(src) << 13) | (32'(en) << 14);
  endfunction

  task automatic chk(logic got, logic exp, string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // disable, check idle level, program, enable, compare n samples to the count model
  task automatic run_wave(int sel, int k, int p, int a, bit pol, bit src, int n, string req);
    int d;
    d = (1 << sel) * (k + 1);
    wr(1'b1, ctrl(k, sel, pol, src, 1'b0));
    repeat (2) @(negedge clk);
    chk(pwm, ~pol, "R10 idle level");
    chk(ready, 1'b1, "R10 ready idle");
    wr(1'b0, {16'(p), 16'(a)});
    wr(1'b1, ctrl(k, sel, pol, src, 1'b1));
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      int c;
      c = (j / d) % (p + 1);
      chk(pwm, (c < a) ? pol : ~pol, req);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm, 1'b0, "R1 reset pwm");
    chk(ready, 1'b1, "R1 reset ready");
    chk(err, 1'b0, "R1 reset err");

    // R2 R4 R5 R3: sweep of divider, prescaler, period, active and polarity
    for (int sel = 0; sel < 3; sel++)
      for (int k = 0; k < 3; k += 2)
        for (int p = 3; p < 6; p += 2)
          for (int ai = 0; ai < 4; ai++)
            for (int pl = 0; pl < 2; pl++) begin
              int a;
              a = (ai == 0) ? 0 : (ai == 1) ? 2 : (ai == 2) ? p + 1 : 65535;
              run_wave(sel, k, p, a, bit'(pl), 1'b0,
                       2 * (1 << sel) * (k + 1) * (p + 1) + 2, "R2 R3 R4 R5 sweep");
            end

    // R3: largest divider; R4: largest prescaler
    run_wave(8, 0, 1, 1, 1'b1, 1'b0, 1030, "R3 S=8");
    run_wave(0, 255, 1, 1, 1'b0, 1'b0, 1030, "R4 K=255");

    // R3: invalid divider select freezes the counter at 0
    wr(1'b1, ctrl(0, 0, 1'b1, 1'b0, 1'b0));
    wr(1'b0, {16'd3, 16'd2});
    wr(1'b1, ctrl(0, 9, 1'b1, 1'b0, 1'b1));
    @(negedge clk);
    for (int j = 0; j < 20; j++) begin
      chk(pwm, 1'b1, "R3 invalid select frozen");
      @(negedge clk);
    end

    // R6: bus tick selected, oscillator idle
    osc_tick = 1'b0; bus_tick = 1'b1;
    run_wave(0, 0, 3, 2, 1'b1, 1'b1, 20, "R6 bus source");
    // R6: oscillator selected while idle, bus ticking: counter stays
    wr(1'b1, ctrl(0, 0, 1'b1, 1'b0, 1'b0));
    wr(1'b1, ctrl(0, 0, 1'b1, 1'b0, 1'b1));
    @(negedge clk);
    for (int j = 0; j < 12; j++) begin
      chk(pwm, 1'b1, "R6 unselected source ignored");
      @(negedge clk);
    end
    osc_tick = 1'b1; bus_tick = 1'b0;

    // R7 R8 R9: mid-period reprogramming with polarity flip and a busy write
    wr(1'b1, ctrl(0, 0, 1'b1, 1'b0, 1'b0));
    wr(1'b0, {16'd9, 16'd5});
    wr(1'b1, ctrl(0, 0, 1'b1, 1'b0, 1'b1));
    @(negedge clk);
    for (int j = 0; j < 30; j++) begin
      int  c;
      logic e;
      c = j % 10;
      e = (j < 10) ? logic'(c < 5) : logic'(!(c < 3));
      chk(pwm, e, "R7 shadowed load");
      if (j == 2)  chk(ready, 1'b1, "R8 ready before write");
      if (j == 4)  chk(ready, 1'b0, "R8 busy after write");
      if (j == 9)  chk(ready, 1'b0, "R8 busy until wrap");
      if (j == 10) chk(ready, 1'b1, "R8 ready after wrap");
      if (j == 5)  chk(err, 1'b0, "R9 err before busy write");
      if (j == 6)  chk(err, 1'b1, "R9 err after busy write");
      if (j == 29) chk(err, 1'b1, "R9 err sticky");
      wr_en = 1'b0;
      if (j == 3) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = {16'd9, 16'd3}; end
      if (j == 4) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = ctrl(0, 0, 1'b0, 1'b0, 1'b1); end
      if (j == 5) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = {16'd9, 16'd8}; end
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R10: disable drives the inactive level of the new polarity (active low)
    wr(1'b1, ctrl(0, 0, 1'b0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    chk(pwm, 1'b1, "R10 disabled inactive");
    chk(ready, 1'b1, "R10 disabled ready");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule